// File: doc/BRIEF.md
# Dual-Edge PDM Capture Front End

This block drives the bit clock of a pulse-density-modulated microphone bus and captures the 1-bit streams that come back on two shared data lines. Each line carries a pair of channels. One channel of the pair is taken on the rising bit-clock edge and the other on the falling edge, which gives four independent 1-bit channel streams. Every stream leaves the block as a bit with a one-cycle valid strobe in the main-clock domain, ready for a decimation stage.

The bit clock comes from the main clock through an 8-bit divider. The whole block runs on the main clock. The bit clock is a registered output, and each data line is resynchronised before it is sampled. The sampling point is placed after a fixed number of main cycles that covers the synchroniser delay.

The clock sequencer is a three-state machine with the states CG_IDLE, CG_HIGH and CG_LOW.
- CG_IDLE moves to CG_HIGH when running is allowed. This move is the first rising edge.
- CG_HIGH moves to CG_LOW, and CG_LOW moves back to CG_HIGH, when the phase counter reaches the divider value. These are the falling and rising edges.
- Any state moves to CG_IDLE when running is withdrawn, and this move makes no edge event.
- Running is allowed while at least one channel is enabled and the soft reset is low.

Top module: `pdm_capture_frontend`

## Requirements
- R1: After reset, `pdm_clk` is 0 and every `smp_vld` bit is 0.
- R2: While running, `pdm_clk` stays high for `clk_div`+1 main cycles and low for `clk_div`+1 main cycles, so the period is 2*(`clk_div`+1). A value of 0 gives the main clock divided by 2.
- R3: `pdm_clk` is held at 0 while `chan_en` is all zero or `soft_rst` is 1. Entering this idle condition produces no sample.
- R4: With `edge_sel[p]` = 0, channel 2p takes the bit of line `pdm_din[p]` captured after a falling edge, and channel 2p+1 takes the bit captured after a rising edge.
- R5: With `edge_sel[p]` = 1, the roles in R4 swap: channel 2p takes the rising edge and channel 2p+1 takes the falling edge.
- R6: For each bit-clock transition, the data line is sampled at the first main-clock edge after that transition. The matching channel's `smp_vld` is high for exactly one cycle, three main-clock edges after the transition, with that value on `smp_bit`. The two channels of a pair never strobe in the same cycle.
- R7: A channel whose `chan_en` bit is 0 gives no strobe. The other channels continue unaffected.
- R8: Asserting `soft_rst` discards samples still in flight and forces all strobes to 0 from the next cycle on. The configuration inputs are left as they are, so the bit clock resumes with the same period once `soft_rst` is released.
- R9: Pair 0 uses only line `pdm_din[0]` and `edge_sel[0]`, and pair 1 uses only `pdm_din[1]` and `edge_sel[1]`. The two pairs can be set to opposite edge settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main working clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous sequencing reset; configuration is kept |
| clk_div | input | 8 | Bit-clock half-period minus one, in main cycles |
| chan_en | input | 4 | Per-channel enable, bit c for channel c |
| edge_sel | input | 2 | Per-pair edge swap, bit p for pair p |
| pdm_din | input | 2 | Shared PDM data lines, bit p for pair p |
| pdm_clk | output | 1 | PDM bit clock to the microphones |
| smp_bit | output | 4 | Captured bit, one per channel |
| smp_vld | output | 4 | One-cycle strobe marking a new captured bit |

## Verification
A sample strobe that is already in the pipeline and a soft reset can arrive in the same main cycle. The bench tracks its own model of pending samples. It raises `soft_rst` in exactly the cycle before a pending sample would strobe, so that the reset and the strobe meet at the same clock edge. The result is correct if no strobe appears then or afterwards. After release, the bit clock must come back with the period it had before, which shows that the reset cleared only sequencing. The bench also switches channel enables and edge settings while samples are in flight, and checks every strobe against the model at the cycle it is due.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;

    // Bit-clock sequencer states
    typedef enum logic [1:0] {
        CG_IDLE = 2'd0,
        CG_HIGH = 2'd1,
        CG_LOW  = 2'd2
    } cg_state_e;

endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen
    import pdm_cap_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [NUM_CH-1:0] chan_en,
    output logic              pdm_clk,
    output logic              rise_evt,
    output logic              fall_evt
);

    cg_state_e        state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic             run;
    logic             phase_done;

    assign run        = (|chan_en) && !soft_rst;
    assign phase_done = (cnt_q >= clk_div);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CG_IDLE: if (run) state_d = CG_HIGH;
            CG_HIGH: begin
                if (!run)            state_d = CG_IDLE;
                else if (phase_done) state_d = CG_LOW;
            end
            CG_LOW: begin
                if (!run)            state_d = CG_IDLE;
                else if (phase_done) state_d = CG_HIGH;
            end
            default: state_d = CG_IDLE;
        endcase
    end

    // State register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered outputs: the pin and the edge events change together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdm_clk  <= 1'b0;
            rise_evt <= 1'b0;
            fall_evt <= 1'b0;
        end else begin
            pdm_clk  <= (state_d == CG_HIGH);
            rise_evt <= (state_d == CG_HIGH) && (state_q != CG_HIGH);
            fall_evt <= (state_d == CG_LOW)  && (state_q == CG_HIGH);
        end
    end

    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pdm_clk);

    a_r2_rise_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |-> (pdm_clk && !$past(pdm_clk)));

    a_r2_fall_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |-> (!pdm_clk && $past(pdm_clk)));

    a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_evt, fall_evt}));

endmodule

// File: rtl/pdm_sync.sv
module pdm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pdm_pair_sampler.sv
module pdm_pair_sampler #(
    parameter int DLY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       rise_evt,
    input  logic       fall_evt,
    input  logic       din_s,
    input  logic       even_on_rise,
    input  logic [1:0] en,
    output logic [1:0] smp_bit,
    output logic [1:0] smp_vld
);

    logic [DLY-1:0] rise_pipe, fall_pipe;
    logic           tap_rise, tap_fall;
    logic           even_hit, odd_hit;

    // Event delay line matching the synchroniser depth
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_pipe <= '0;
            fall_pipe <= '0;
        end else if (soft_rst) begin
            rise_pipe <= '0;
            fall_pipe <= '0;
        end else begin
            rise_pipe[0] <= rise_evt;
            fall_pipe[0] <= fall_evt;
            for (int i = 1; i < DLY; i++) begin
                rise_pipe[i] <= rise_pipe[i-1];
                fall_pipe[i] <= fall_pipe[i-1];
            end
        end
    end

    assign tap_rise = rise_pipe[DLY-1];
    assign tap_fall = fall_pipe[DLY-1];
    assign even_hit = even_on_rise ? tap_rise : tap_fall;
    assign odd_hit  = even_on_rise ? tap_fall : tap_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_vld <= '0;
            smp_bit <= '0;
        end else if (soft_rst) begin
            smp_vld <= '0;
        end else begin
            smp_vld[0] <= even_hit && en[0];
            smp_vld[1] <= odd_hit  && en[1];
            if (even_hit) smp_bit[0] <= din_s;
            if (odd_hit)  smp_bit[1] <= din_s;
        end
    end

    a_r6_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_vld[0] && smp_vld[1]));

    a_r7_even_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en[0]) |-> !smp_vld[0]);

    a_r7_odd_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en[1]) |-> !smp_vld[1]);

    a_r8_soft_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (smp_vld == 2'b00));

endmodule

// File: rtl/pdm_capture_frontend.sv
module pdm_capture_frontend #(
    parameter int DIV_W       = 8,
    parameter int NUM_PAIRS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic [DIV_W-1:0]       clk_div,
    input  logic [2*NUM_PAIRS-1:0] chan_en,
    input  logic [NUM_PAIRS-1:0]   edge_sel,
    input  logic [NUM_PAIRS-1:0]   pdm_din,
    output logic                   pdm_clk,
    output logic [2*NUM_PAIRS-1:0] smp_bit,
    output logic [2*NUM_PAIRS-1:0] smp_vld
);

    localparam int NUM_CH = 2 * NUM_PAIRS;

    logic                 rise_evt, fall_evt;
    logic [NUM_PAIRS-1:0] din_s;

    pdm_clkgen #(
        .DIV_W  (DIV_W),
        .NUM_CH (NUM_CH)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .clk_div  (clk_div),
        .chan_en  (chan_en),
        .pdm_clk  (pdm_clk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    pdm_sync #(
        .WIDTH  (NUM_PAIRS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pdm_din),
        .dout  (din_s)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        pdm_pair_sampler #(
            .DLY (SYNC_STAGES)
        ) u_smp (
            .clk          (clk),
            .rst_n        (rst_n),
            .soft_rst     (soft_rst),
            .rise_evt     (rise_evt),
            .fall_evt     (fall_evt),
            .din_s        (din_s[p]),
            .even_on_rise (edge_sel[p]),
            .en           (chan_en[2*p +: 2]),
            .smp_bit      (smp_bit[2*p +: 2]),
            .smp_vld      (smp_vld[2*p +: 2])
        );
    end

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pdm_clk) && !$past(pdm_clk, 2) && !$past(pdm_clk, 3) && !$past(pdm_clk, 4)
        |-> (smp_vld == '0));

endmodule

// File: tb/sim_pdm_capture_frontend.sv
module sim_pdm_capture_frontend;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [7:0] clk_div = 8'd1;
    logic [3:0] chan_en = 4'h0;
    logic [1:0] edge_sel = 2'b00;
    logic [1:0] pdm_din = 2'b00;
    logic       pdm_clk;
    logic [3:0] smp_bit, smp_vld;

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R6";
    int strobes [4];

    // reference model pipeline
    logic       p_evt [3];
    logic       p_rise [3];
    logic [1:0] p_bits [3];
    logic       prev_clk = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdm_capture_frontend u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clk_div(clk_div),
        .chan_en(chan_en), .edge_sel(edge_sel), .pdm_din(pdm_din),
        .pdm_clk(pdm_clk), .smp_bit(smp_bit), .smp_vld(smp_vld)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Data driver and strobe checker, both at the falling clock edge
    initial begin
        for (int i = 0; i < 3; i++) begin
            p_evt[i] = 1'b0; p_rise[i] = 1'b0; p_bits[i] = 2'b00;
        end
        forever begin
            @(negedge clk);
            if (rst_n) begin
                logic [3:0] ev, eb;
                ev = '0; eb = '0;
                if (!soft_rst && p_evt[2]) begin
                    for (int q = 0; q < 2; q++) begin
                        int tgt;
                        tgt = (p_rise[2] == edge_sel[q]) ? 2*q : 2*q + 1;
                        ev[tgt] = chan_en[tgt];
                        eb[tgt] = p_bits[2][q];
                    end
                end
                for (int c = 0; c < 4; c++) begin
                    if (smp_vld[c]) strobes[c]++;
                    if (ev[c] || smp_vld[c]) begin
                        chk((smp_vld[c] == ev[c]) && (!ev[c] || smp_bit[c] == eb[c]),
                            $sformatf("%s ch%0d", cur_tag, c),
                            {smp_vld[c], smp_bit[c]}, {ev[c], eb[c]});
                    end
                end
                if (soft_rst) begin
                    for (int i = 0; i < 3; i++) p_evt[i] = 1'b0;
                end else begin
                    p_evt[2] = p_evt[1]; p_rise[2] = p_rise[1]; p_bits[2] = p_bits[1];
                    p_evt[1] = p_evt[0]; p_rise[1] = p_rise[0]; p_bits[1] = p_bits[0];
                    p_evt[0] = 1'b0;
                    if ((pdm_clk != prev_clk) && (|chan_en)) begin
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        pdm_din   = lfsr[1:0];
                        p_evt[0]  = 1'b1;
                        p_rise[0] = pdm_clk;
                        p_bits[0] = lfsr[1:0];
                    end
                end
            end
            prev_clk = pdm_clk;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic set_cfg(input logic [3:0] en, input logic [1:0] es, input logic [7:0] dv);
        @(negedge clk); #1;
        chan_en = en; edge_sel = es; clk_div = dv;
    endtask

    task automatic clear_counts();
        for (int c = 0; c < 4; c++) strobes[c] = 0;
    endtask

    task automatic measure(output int hi, output int lo);
        @(negedge clk);
        while (pdm_clk !== 1'b0) @(negedge clk);
        while (pdm_clk === 1'b0) @(negedge clk);
        hi = 0;
        while (pdm_clk === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (pdm_clk === 1'b0) begin lo++; @(negedge clk); end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(pdm_clk == 1'b0, "R1 clk", pdm_clk, 0);
        chk(smp_vld == 4'h0, "R1 vld", smp_vld, 0);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(pdm_clk == 1'b0, "R3 no enable", pdm_clk, 0);
    endtask

    task automatic t_period(input logic [7:0] dv);
        int hi, lo;
        cur_tag = "R2";
        set_cfg(4'hF, 2'b00, dv);
        measure(hi, lo);
        chk(hi == dv + 1, "R2 high phase", hi, dv + 1);
        chk(lo == dv + 1, "R2 low phase", lo, dv + 1);
    endtask

    task automatic t_edges(input logic [1:0] es, input string tag);
        cur_tag = tag;
        set_cfg(4'hF, es, 8'd2);
        clear_counts();
        repeat (90) @(negedge clk);
        for (int c = 0; c < 4; c++)
            chk(strobes[c] >= 10 && strobes[c] <= 20, {tag, " strobe count"}, strobes[c], 15);
    endtask

    task automatic t_disable();
        cur_tag = "R7";
        set_cfg(4'b1101, 2'b01, 8'd1);
        clear_counts();
        repeat (60) @(negedge clk);
        chk(strobes[1] == 0, "R7 disabled ch1", strobes[1], 0);
        chk(strobes[0] > 0, "R7 ch0 live", strobes[0], 1);
        chk(strobes[3] > 0, "R7 ch3 live", strobes[3], 1);
    endtask

    task automatic t_idle();
        int highs;
        cur_tag = "R3";
        set_cfg(4'h0, 2'b00, 8'd1);
        highs = 0;
        repeat (3) @(negedge clk);
        clear_counts();
        repeat (20) begin
            @(negedge clk);
            if (pdm_clk) highs++;
        end
        chk(highs == 0, "R3 clk low when disabled", highs, 0);
        chk(strobes[0] + strobes[1] + strobes[2] + strobes[3] == 0, "R3 no strobes", strobes[0], 0);
        set_cfg(4'hF, 2'b00, 8'd1);
        repeat (10) @(negedge clk);
        #1 soft_rst = 1'b1;
        highs = 0;
        repeat (10) begin
            @(negedge clk);
            if (pdm_clk) highs++;
        end
        chk(highs == 0, "R3 clk low in soft reset", highs, 0);
        #1 soft_rst = 1'b0;
    endtask

    task automatic t_collide();
        int hi0, lo0, hi1, lo1;
        cur_tag = "R8";
        set_cfg(4'hF, 2'b10, 8'd3);
        measure(hi0, lo0);
        do begin
            @(negedge clk); #1;
        end while (!p_evt[2]);
        soft_rst = 1'b1;
        clear_counts();
        repeat (6) @(negedge clk);
        chk(strobes[0] + strobes[1] + strobes[2] + strobes[3] == 0, "R8 pending sample dropped",
            strobes[0] + strobes[1] + strobes[2] + strobes[3], 0);
        #1 soft_rst = 1'b0;
        measure(hi1, lo1);
        chk(hi1 == hi0 && lo1 == lo0, "R8 period kept", hi1 + lo1, hi0 + lo0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_period(8'd0);
        t_period(8'd3);
        t_period(8'd9);
        t_edges(2'b00, "R4");
        t_edges(2'b11, "R5");
        t_edges(2'b01, "R9");
        t_edges(2'b10, "R9");
        cur_tag = "R6";
        set_cfg(4'hF, 2'b00, 8'd0);
        repeat (40) @(negedge clk);
        t_disable();
        t_idle();
        t_collide();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule